// File: doc/BRIEF.md
# Display Line Timing and Status Unit

This block generates the line and dot timing for a 160 by 144 line-based display controller. A dot counter runs through each line and a line counter runs through a frame of 154 lines. The last ten lines are a vertical blanking interval. From these two counters the unit derives a two-bit phase code that tells the rest of the chip who owns the display memories at that moment: horizontal blank, vertical blank, sprite table search, or pixel transfer.

A compare register is matched against the current line. The match is shown as a flag and can raise an interrupt. Four per-condition enables are folded into one status interrupt request, and a separate request marks the start of vertical blanking. Software reaches the unit through four 8-bit registers: control, status, current line and compare line. Rendering, fetching and memory arbitration sit outside it and only consume the phase code and line number.

No data streams through the unit. Its register port and its timing and interrupt outputs are plain control and status pins with no handshake, so there is nothing to apply back-pressure to.

Top module: `lcd_line_timer`

## Requirements
- R1: While the display runs, the dot counter advances once per clock through 456 dots per line. At the end of each line the line counter steps by one, wrapping from 153 back to 0, and line_o never exceeds 153.
- R2: mode_o (and status bits 1:0) reads 01 on lines 144 to 153. On lines 0 to 143 it reads 10 for dots 0 to 79, 11 for dots 80 to 251 and 00 for dots 252 to 455.
- R3: Status bit 2 reads 1 exactly when the display runs and the current line equals the compare register. It reads 0 while the display is off.
- R4: A status write stores data bits 6:3 as the condition enables: bit 3 horizontal blank, bit 4 vertical blank, bit 5 sprite search, bit 6 line match. Written bits 2:0 and 7 are ignored, and status bit 7 reads 0.
- R5: stat_irq is a one-clock pulse, registered, in the clock after the OR of the enabled conditions goes from 0 to 1. A condition that stays true, or that overlaps another already true, does not pulse again.
- R6: Any write to the current-line register (address 2) sets the line and dot counters to 0 at that clock edge, whatever the data.
- R7: vblank_irq is high for exactly the first clock in which line_o reads 144. A line-register write at the last dot of line 143 takes priority, and no pulse then follows.
- R8: With control bit 7 at 0, both counters are cleared and mode_o reads 00. The clock after bit 7 is written to 1, line 0 starts at dot 0 in mode 10.
- R9: After reset all registers read 0 and mode_o, line_o, vblank_irq and stat_irq are 0.
- R10: reg_rdata returns, by reg_addr: 0 the full 8-bit control register, 1 status, 2 current line, 3 compare line. Control and compare keep all 8 written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 line, 3 compare |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| mode_o | output | 2 | Memory-ownership phase code |
| line_o | output | 8 | Current line number |
| vblank_irq | output | 1 | Vertical blank start request pulse |
| stat_irq | output | 1 | Status condition request pulse |

## Verification
The assertions assume that reg_wr and reg_addr are stable across each rising edge and are free of X after reset. They also assume that a write to the line register is an ordinary write, so a cleared line count is what they expect to see after it. The stimulus drives every register input on the falling edge and holds reg_wr for exactly one clock per write. It changes reg_addr for reads only while reg_wr is low, so no read alters state. Writes are timed against a behavioural model of the frame, which places one of them on the last dot of line 143 to exercise the priority case.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  typedef enum logic [1:0] {
    PH_HBLANK = 2'b00,
    PH_VBLANK = 2'b01,
    PH_SEARCH = 2'b10,
    PH_XFER   = 2'b11
  } phase_e;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_STAT  = 2'd1;
  localparam logic [1:0] RA_LINE  = 2'd2;
  localparam logic [1:0] RA_MATCH = 2'd3;

  localparam int CTRL_RUN_BIT = 7;
  localparam int STAT_IE_LSB  = 3;
  localparam int NUM_SRC      = 4;

endpackage

// File: rtl/lcdt_counters.sv
module lcdt_counters #(
  parameter int DOTS  = 456,
  parameter int LINES = 154,
  parameter int DW    = $clog2(DOTS),
  parameter int LW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  output logic [DW-1:0] dot_q,
  output logic [LW-1:0] line_q,
  output logic          line_end
);

  localparam logic [DW-1:0] LAST_DOT  = DW'(DOTS - 1);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

  assign line_end = run && (dot_q == LAST_DOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot_q  <= '0;
      line_q <= '0;
    end else if (!run || restart) begin
      dot_q  <= '0;
      line_q <= '0;
    end else if (line_end) begin
      dot_q  <= '0;
      line_q <= (line_q == LAST_LINE) ? '0 : line_q + LW'(1);
    end else begin
      dot_q <= dot_q + DW'(1);
    end
  end

endmodule

// File: rtl/lcdt_phase.sv
module lcdt_phase
  import lcdt_pkg::*;
#(
  parameter int SEARCH_DOTS = 80,
  parameter int XFER_DOTS   = 172,
  parameter int VIS_LINES   = 144,
  parameter int DW          = 9,
  parameter int LW          = 8
) (
  input  logic          run,
  input  logic [DW-1:0] dot,
  input  logic [LW-1:0] line,
  input  logic [7:0]    match_line,
  output logic [1:0]    phase,
  output logic          coinc
);

  localparam logic [DW-1:0] XFER_START = DW'(SEARCH_DOTS);
  localparam logic [DW-1:0] HB_START   = DW'(SEARCH_DOTS + XFER_DOTS);
  localparam logic [LW-1:0] VB_FIRST   = LW'(VIS_LINES);

  phase_e ph;

  always_comb begin
    if (!run)                 ph = PH_HBLANK;
    else if (line >= VB_FIRST) ph = PH_VBLANK;
    else if (dot < XFER_START) ph = PH_SEARCH;
    else if (dot < HB_START)   ph = PH_XFER;
    else                       ph = PH_HBLANK;
  end

  assign phase = ph;
  assign coinc = run && (8'(line) == match_line);

endmodule

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  input  logic [LW-1:0] line,
  input  logic [1:0]    phase,
  input  logic          coinc,
  output logic [7:0]    rdata,
  output logic          run,
  output logic [NUM_SRC-1:0] cond_en,
  output logic [7:0]    match_line,
  output logic          line_clear
);

  logic [7:0]         ctrl_q;
  logic [NUM_SRC-1:0] ie_q;
  logic [7:0]         match_q;

  assign line_clear = wr && (addr == RA_LINE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ie_q    <= '0;
      match_q <= '0;
    end else if (wr) begin
      case (addr)
        RA_CTRL:  ctrl_q  <= wdata;
        RA_STAT:  ie_q    <= wdata[STAT_IE_LSB +: NUM_SRC];
        RA_MATCH: match_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      RA_CTRL:  rdata = ctrl_q;
      RA_STAT:  rdata = {1'b0, ie_q, coinc, phase};
      RA_LINE:  rdata = 8'(line);
      default:  rdata = match_q;
    endcase
  end

  assign run        = ctrl_q[CTRL_RUN_BIT];
  assign cond_en    = ie_q;
  assign match_line = match_q;

endmodule

// File: rtl/lcdt_irq.sv
module lcdt_irq
  import lcdt_pkg::*;
#(
  parameter int VIS_LINES = 144,
  parameter int LW        = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic               line_end,
  input  logic [LW-1:0]      line,
  input  logic [1:0]         phase,
  input  logic               coinc,
  input  logic [NUM_SRC-1:0] cond_en,
  output logic               stat_irq,
  output logic               vblank_irq
);

  localparam logic [LW-1:0] LAST_VIS = LW'(VIS_LINES - 1);

  logic [NUM_SRC-1:0] src;
  logic [NUM_SRC-1:0] gated;
  logic               cond_now;
  logic               cond_q;

  assign src[0] = (phase == PH_HBLANK);
  assign src[1] = (phase == PH_VBLANK);
  assign src[2] = (phase == PH_SEARCH);
  assign src[3] = coinc;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
    assign gated[g] = cond_en[g] & src[g];
  end

  assign cond_now = run && (|gated);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q     <= 1'b0;
      stat_irq   <= 1'b0;
      vblank_irq <= 1'b0;
    end else begin
      cond_q     <= cond_now;
      stat_irq   <= cond_now && !cond_q;
      vblank_irq <= line_end && !restart && (line == LAST_VIS);
    end
  end

endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
  import lcdt_pkg::*;
#(
  parameter int DOTS_PER_LINE = 456,
  parameter int SEARCH_DOTS   = 80,
  parameter int XFER_DOTS     = 172,
  parameter int VIS_LINES     = 144,
  parameter int TOTAL_LINES   = 154,
  localparam int DOT_W        = $clog2(DOTS_PER_LINE),
  localparam int LINE_W       = $clog2(TOTAL_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [1:0]        mode_o,
  output logic [LINE_W-1:0] line_o,
  output logic              vblank_irq,
  output logic              stat_irq
);

  logic               disp_en;
  logic               line_clear;
  logic               line_end;
  logic               coinc;
  logic [DOT_W-1:0]   dot;
  logic [LINE_W-1:0]  line;
  logic [1:0]         phase;
  logic [7:0]         match_line;
  logic [NUM_SRC-1:0] cond_en;

  lcdt_regs #(.LW(LINE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .line       (line),
    .phase      (phase),
    .coinc      (coinc),
    .rdata      (reg_rdata),
    .run        (disp_en),
    .cond_en    (cond_en),
    .match_line (match_line),
    .line_clear (line_clear)
  );

  lcdt_counters #(
    .DOTS  (DOTS_PER_LINE),
    .LINES (TOTAL_LINES),
    .DW    (DOT_W),
    .LW    (LINE_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (disp_en),
    .restart  (line_clear),
    .dot_q    (dot),
    .line_q   (line),
    .line_end (line_end)
  );

  lcdt_phase #(
    .SEARCH_DOTS (SEARCH_DOTS),
    .XFER_DOTS   (XFER_DOTS),
    .VIS_LINES   (VIS_LINES),
    .DW          (DOT_W),
    .LW          (LINE_W)
  ) u_phase (
    .run        (disp_en),
    .dot        (dot),
    .line       (line),
    .match_line (match_line),
    .phase      (phase),
    .coinc      (coinc)
  );

  lcdt_irq #(
    .VIS_LINES (VIS_LINES),
    .LW        (LINE_W)
  ) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (disp_en),
    .restart    (line_clear),
    .line_end   (line_end),
    .line       (line),
    .phase      (phase),
    .coinc      (coinc),
    .cond_en    (cond_en),
    .stat_irq   (stat_irq),
    .vblank_irq (vblank_irq)
  );

  assign mode_o = phase;
  assign line_o = line;

endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker #(
  parameter int VIS_LINES   = 144,
  parameter int TOTAL_LINES = 154,
  parameter int LW          = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [1:0]    mode_o,
  input logic [LW-1:0] line_o,
  input logic          vblank_irq,
  input logic          stat_irq,
  input logic          disp_en
);

  p_line_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(line_o) < TOTAL_LINES);

  p_vblank_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && int'(line_o) >= VIS_LINES) |-> (mode_o == 2'b01));

  p_stat_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_irq |=> !stat_irq);

  p_line_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> (line_o == '0));

  p_vbl_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |-> (int'(line_o) == VIS_LINES));

  p_vbl_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |=> !vblank_irq);

  p_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> (line_o == '0));

  p_off_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (mode_o == 2'b00 && !vblank_irq));

endmodule

bind lcd_line_timer lcdt_checker #(
  .VIS_LINES   (VIS_LINES),
  .TOTAL_LINES (TOTAL_LINES),
  .LW          (LINE_W)
) u_lcdt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .mode_o     (mode_o),
  .line_o     (line_o),
  .vblank_irq (vblank_irq),
  .stat_irq   (stat_irq),
  .disp_en    (disp_en)
);

// File: tb/test_lcd_line_timer.sv
`timescale 1ns/1ps
module test_lcd_line_timer;

  localparam int CYC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] mode_o;
  logic [7:0] line_o;
  logic       vblank_irq;
  logic       stat_irq;

  int tests = 0;
  int fails = 0;
  bit live  = 0;

  int m_en, m_dot, m_line, m_ctrl, m_ie, m_cmp, m_prev, e_stat, e_vbl;

  always #(CYC/2) clk = ~clk;

  lcd_line_timer i_lcd_line_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_o(mode_o),
    .line_o(line_o), .vblank_irq(vblank_irq), .stat_irq(stat_irq)
  );

  function automatic int ref_phase(int en, int ln, int dt);
    if (en == 0) return 0;
    if (ln >= 144) return 1;
    if (dt < 80) return 2;
    if (dt < 252) return 3;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural frame model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_dot = 0; m_line = 0; m_ctrl = 0; m_ie = 0; m_cmp = 0;
      m_prev = 0; e_stat = 0; e_vbl = 0;
    end else begin
      int ph, cond, hit, lw;
      lw   = (reg_wr && reg_addr == 2'd2) ? 1 : 0;
      ph   = ref_phase(m_en, m_line, m_dot);
      hit  = (m_en != 0 && m_line == m_cmp) ? 1 : 0;
      cond = (m_en != 0 && ((m_ie[0] && ph == 0) || (m_ie[1] && ph == 1) ||
              (m_ie[2] && ph == 2) || (m_ie[3] && hit != 0))) ? 1 : 0;
      e_stat = (cond != 0 && m_prev == 0) ? 1 : 0;
      m_prev = cond;
      e_vbl  = (m_en != 0 && lw == 0 && m_line == 143 && m_dot == 455) ? 1 : 0;
      if (m_en == 0 || lw != 0) begin
        m_dot = 0; m_line = 0;
      end else if (m_dot == 455) begin
        m_dot = 0; m_line = (m_line == 153) ? 0 : m_line + 1;
      end else m_dot = m_dot + 1;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: begin m_ctrl = int'(reg_wdata); m_en = int'(reg_wdata[7]); end
          2'd1: m_ie = int'(reg_wdata[6:3]);
          2'd3: m_cmp = int'(reg_wdata);
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live) begin
      chk("R1 line_o", int'(line_o), m_line);
      chk("R2 mode_o", int'(mode_o), ref_phase(m_en, m_line, m_dot));
      chk("R5 stat_irq", int'(stat_irq), e_stat);
      chk("R7 vblank_irq", int'(vblank_irq), e_vbl);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic wait_at(input int ln, input int dt);
    while (!(m_line == ln && m_dot == dt)) @(negedge clk);
  endtask

  initial begin
    #(CYC * 190000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1;
    // R9 reset state, R10 read map
    chk("R9 mode after reset", int'(mode_o), 0);
    chk("R9 line after reset", int'(line_o), 0);
    rd(2'd0, 0, "R9 ctrl reset");
    rd(2'd1, 0, "R9 status reset");
    rd(2'd3, 0, "R9 compare reset");
    // R4: only bits 6:3 take effect; display off so flag and mode are 0
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h78, "R4 status write masks");
    wr(2'd3, 8'd5);
    rd(2'd3, 5, "R10 compare readback");
    rd(2'd2, 0, "R8 line held while off");
    wr(2'd0, 8'h91);
    rd(2'd0, 8'h91, "R10 control readback");
    chk("R8 enable starts in search", int'(mode_o), 2);
    chk("R8 enable starts at line 0", int'(line_o), 0);
    // R3: coincidence on line 5 during transfer
    wait_at(5, 100);
    rd(2'd1, 8'h7F, "R3 status with match");
    wait_at(6, 0);
    rd(2'd1, 8'h7A, "R3 status without match");
    // R7 vertical blank entry
    wait_at(143, 455);
    @(negedge clk);
    chk("R7 vblank pulse at 144", int'(vblank_irq), 1);
    @(negedge clk);
    chk("R7 vblank single cycle", int'(vblank_irq), 0);
    wait_at(150, 10);
    rd(2'd1, 8'h79, "R2 status in vblank");
    rd(2'd2, 150, "R10 line readback");
    // R1 wrap to next frame
    wait_at(153, 455);
    @(negedge clk);
    chk("R1 wrap to line 0", int'(line_o), 0);
    chk("R1 wrap mode", int'(mode_o), 2);
    // R6 line write mid-frame, coincidence enable only
    wr(2'd1, 8'h40);
    wr(2'd3, 8'd20);
    wait_at(20, 30);
    rd(2'd2, 20, "R6 line before write");
    wr(2'd2, 8'hA5);
    rd(2'd2, 0, "R6 line cleared by write");
    rd(2'd1, 8'h42, "R6 status after clear");
    // R7 priority: line write on last dot of line 143
    wr(2'd1, 8'h28);
    wait_at(143, 455);
    wr(2'd2, 8'h00);
    chk("R7 no vblank when cleared", int'(vblank_irq), 0);
    chk("R6 line after collision", int'(line_o), 0);
    repeat (600) @(negedge clk);
    // R8 display off and back on
    wr(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    chk("R8 line off", int'(line_o), 0);
    chk("R8 mode off", int'(mode_o), 0);
    rd(2'd1, 8'h28, "R8 status while off");
    wr(2'd0, 8'h80);
    rd(2'd1, 8'h2A, "R8 status after enable");
    repeat (1000) @(negedge clk);
    live = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule